// File: doc/BRIEF.md
# Clock Gate Set/Clear Register Bank

This block holds the on/off state for a group of clock gates and drives one glitch-free gating cell per gate. Software reaches it through a small synchronous register port with three word addresses. A status word reports which gates are running. A set word turns gates on, and a clear word turns gates off. Because each bit written as one acts on exactly one gate, and zero bits act on none, several agents can each control their own gates without a read-modify-write of a shared word.

Each gate has its own input clock and its own gated output clock. Gate n uses bit n in all three words. The reset value of every gate is a parameter, so selected clocks can already be running when reset is released. Each gating cell samples its enable only while its input clock is low. An enable change therefore shows up at the next rising edge of that clock and never cuts a high phase short.

Top module: `clkgate_bank`

## Requirements
- R1: After reset, bit n of the status word (byte address 0x0) equals bit n of the parameter RESET_EN.
- R2: A write to the set word (byte address 0x4) turns on every gate whose bit in the written data is 1, and leaves the gates whose bit is 0 unchanged.
- R3: A write to the clear word (byte address 0x8) turns off every gate whose bit in the written data is 1, and leaves the gates whose bit is 0 unchanged.
- R4: A read of the status word returns the gate states in bits NUM_GATES-1..0 and zero in all higher bits. Written data bits at or above NUM_GATES have no effect.
- R5: Reads of the set word and of the clear word return zero.
- R6: Writes to the status word, and writes to any address other than 0x4 or 0x8 (for example 0xC), leave every gate state unchanged.
- R7: Read data is combinational from the address. A read in the cycle right after an accepted write returns the state that write produced.
- R8: While gate n is enabled, gate_clk_out[n] follows gate_clk_in[n]. While gate n is disabled, gate_clk_out[n] stays low.
- R9: gate_clk_out[n] is never high while gate_clk_in[n] is low. If the enable changes during a high phase of gate_clk_in[n], the output keeps its current level until that input clock next goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge of clk |
| bus_wdata | input | DATA_W | Write data, one bit per gate |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| gate_clk_in | input | NUM_GATES | Clocks to be gated, one per gate |
| gate_clk_out | output | NUM_GATES | Gated clocks, one per gate |

## Verification
The checker samples on the rising edge of clk. Its no-runt check assumes that no gate input clock changes at that instant. The bench guarantees this by shifting the gate clock edges 1 ns away from the clk edges. The state-update checks assume that bus_we, bus_addr and bus_wdata are stable around each rising clk edge, so the bench drives them only on falling edges. The bench changes enables at known points of the gate clock phase to exercise the case where an update arrives during a high phase.

// File: rtl/clkgate_pkg.sv
// Package: shared register offsets and access-select type for the clock gate bank.
// Assumes byte addressing with word-aligned registers.
package clkgate_pkg;
    localparam int unsigned OFF_STAT = 0;
    localparam int unsigned OFF_SET  = 4;
    localparam int unsigned OFF_CLR  = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_SET  = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/clkgate_decode.sv
// Module: maps a byte address to one of the three bank registers.
// Assumes exact address match; every other address selects nothing.
module clkgate_decode
    import clkgate_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Purpose: pick the register that the address names.
    always_comb begin
        if (addr == ADDR_W'(OFF_STAT))      sel = SEL_STAT;
        else if (addr == ADDR_W'(OFF_SET))  sel = SEL_SET;
        else if (addr == ADDR_W'(OFF_CLR))  sel = SEL_CLR;
        else                                sel = SEL_NONE;
    end
endmodule

// File: rtl/clkgate_state.sv
// Module: per-gate enable flops, updated by set or clear strobes.
// Assumes at most one strobe per cycle (they come from one decoded address).
module clkgate_state #(
    parameter int unsigned         NUM_GATES = 8,
    parameter logic [NUM_GATES-1:0] RESET_EN = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_stb,
    input  logic                 clr_stb,
    input  logic [NUM_GATES-1:0] wbits,
    output logic [NUM_GATES-1:0] en
);
    // Purpose: hold enables; ones in wbits set or clear, zeros keep.
    always_ff @(posedge clk) begin
        if (!rst_n)       en <= RESET_EN;
        else if (set_stb) en <= en | wbits;
        else if (clr_stb) en <= en & ~wbits;
    end
endmodule

// File: rtl/clkgate_cell.sv
// Module: glitch-free clock gate with a low-transparent enable latch.
// Assumes en is held steady near the rising edge of clk_in, or a change is
// tolerated one period late; the output can only rise with clk_in.
module clkgate_cell (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // Purpose: capture the enable only during the low phase of clk_in.
    always_latch begin
        if (!clk_in) en_lat = en;
    end

    assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/clkgate_bank.sv
// Module: clock gate bank with status, set and clear words and one gate cell
// per bit. Assumes NUM_GATES <= DATA_W and a synchronous, single-cycle port.
module clkgate_bank
    import clkgate_pkg::*;
#(
    parameter int unsigned          NUM_GATES = 8,
    parameter int unsigned          ADDR_W    = 4,
    parameter int unsigned          DATA_W    = 32,
    parameter logic [NUM_GATES-1:0] RESET_EN  = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_GATES-1:0] gate_clk_in,
    output logic [NUM_GATES-1:0] gate_clk_out
);
    reg_sel_e             sel;
    logic [NUM_GATES-1:0] gate_en;

    clkgate_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    clkgate_state #(.NUM_GATES(NUM_GATES), .RESET_EN(RESET_EN)) st_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_we && (sel == SEL_SET)),
        .clr_stb (bus_we && (sel == SEL_CLR)),
        .wbits   (bus_wdata[NUM_GATES-1:0]),
        .en      (gate_en)
    );

    generate
        if (DATA_W > NUM_GATES) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_GATES];
        end
    endgenerate

    // Purpose: return status on its own address and zero everywhere else.
    always_comb begin
        bus_rdata = '0;
        if (sel == SEL_STAT) bus_rdata[NUM_GATES-1:0] = gate_en;
    end

    generate
        for (genvar g = 0; g < NUM_GATES; g++) begin : g_cell
            clkgate_cell cell_i (
                .clk_in  (gate_clk_in[g]),
                .en      (gate_en[g]),
                .clk_out (gate_clk_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/clkgate_bank_chk.sv
// Module: assertion checker for clkgate_bank, attached by bind.
// Assumes bus inputs are stable at clk edges and no gate clock edge meets one.
module clkgate_bank_chk #(
    parameter int unsigned NUM_GATES = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_GATES-1:0] gate_en,
    input logic [NUM_GATES-1:0] gate_clk_in,
    input logic [NUM_GATES-1:0] gate_clk_out
);
    logic wr_set, wr_clr;
    assign wr_set = bus_we && (bus_addr == ADDR_W'(4));
    assign wr_clr = bus_we && (bus_addr == ADDR_W'(8));

    assert_set_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((gate_en & $past(bus_wdata[NUM_GATES-1:0])) == $past(bus_wdata[NUM_GATES-1:0])));

    assert_clr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((gate_en & $past(bus_wdata[NUM_GATES-1:0])) == '0));

    assert_zero_bits_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> ((gate_en & ~$past(bus_wdata[NUM_GATES-1:0]))
                                == ($past(gate_en) & ~$past(bus_wdata[NUM_GATES-1:0]))));

    assert_other_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(gate_en));

    assert_action_words_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == ADDR_W'(4)) || (bus_addr == ADDR_W'(8))) |-> (bus_rdata == '0));

    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata == DATA_W'(gate_en)));

    generate
        for (genvar g = 0; g < NUM_GATES; g++) begin : g_runt
            assert_no_runt_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !gate_clk_in[g] |-> !gate_clk_out[g]);
        end
    endgenerate
endmodule

bind clkgate_bank clkgate_bank_chk #(
    .NUM_GATES (NUM_GATES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .gate_en      (gate_en),
    .gate_clk_in  (gate_clk_in),
    .gate_clk_out (gate_clk_out)
);

// File: tb/clkgate_bank_tb_top.sv
// Bench: scoreboard for clkgate_bank. Driver tasks queue expected read data,
// a monitor pops and compares; gate clock checks are made directly.
module clkgate_bank_tb_top;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          gclk = 1'b0;
    logic [N-1:0]  gate_clk_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_en;
    logic [31:0]  exp_q[$];
    string        tag_q[$];
    logic         rd_pending = 1'b0;
    logic         done = 1'b0;

    clkgate_bank #(.NUM_GATES(N), .ADDR_W(4), .DATA_W(32), .RESET_EN(8'h03)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .gate_clk_in  ({N{gclk}}),
        .gate_clk_out (gate_clk_out)
    );

    always #2.5 clk = ~clk;
    initial begin
        #1;
        forever #10 gclk = ~gclk;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge, returns at the next one.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 4'h4) exp_en = exp_en | d[N-1:0];
        else if (a == 4'h8) exp_en = exp_en & ~d[N-1:0];
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string req);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(req);
        rd_pending = 1'b1;
        @(negedge clk);
        rd_pending = 1'b0;
    endtask

    // Monitor: compare read data with the queued expectation.
    always @(negedge clk) begin
        #1;
        if (rd_pending && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata == e, t, bus_rdata, e);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        exp_en = 8'h03;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        bus_read(4'h0, 32'h03, "R1 reset status");
        bus_read(4'h4, 32'h0, "R5 set word reads zero");
        bus_read(4'h8, 32'h0, "R5 clear word reads zero");

        bus_write(4'h4, 32'h30);
        bus_read(4'h0, {24'h0, exp_en}, "R2 R7 set then read next cycle");
        bus_write(4'h8, 32'h01);
        bus_read(4'h0, {24'h0, exp_en}, "R3 clear bit 0");
        bus_write(4'h4, 32'h0);
        bus_write(4'h8, 32'h0);
        bus_read(4'h0, {24'h0, exp_en}, "R2 R3 zero data keeps state");
        bus_write(4'h0, 32'hFF);
        bus_read(4'h0, {24'h0, exp_en}, "R6 status write ignored");
        bus_write(4'hC, 32'hFF);
        bus_read(4'h0, {24'h0, exp_en}, "R6 unmapped write ignored");
        bus_write(4'h4, 32'hFFFF_FF00);
        bus_read(4'h0, {24'h0, exp_en}, "R4 high data bits ignored");
        bus_write(4'h4, 32'hFF);
        bus_write(4'h8, 32'hAA);
        bus_read(4'h0, {24'h0, exp_en}, "R4 status after set and clear");

        // R8: gated outputs in both phases.
        @(posedge gclk); #2;
        check(gate_clk_out == exp_en, "R8 high phase", {24'h0, gate_clk_out}, {24'h0, exp_en});
        @(negedge gclk); #2;
        check(gate_clk_out == '0, "R8 low phase", {24'h0, gate_clk_out}, 32'h0);

        // R9: enable bit 1 during a high phase; it must not start early.
        @(posedge gclk);
        @(negedge clk);
        bus_addr = 4'h4; bus_we = 1'b1; bus_wdata = 32'h02;
        @(posedge clk); #1;
        check(gclk == 1'b1 && gate_clk_out[1] == 1'b0, "R9 no early start",
              {31'h0, gate_clk_out[1]}, 32'h0);
        @(negedge clk);
        bus_we = 1'b0;
        exp_en = exp_en | 8'h02;

        // R9: disable bit 0 during a high phase; it must not cut the pulse.
        @(posedge gclk);
        @(negedge clk);
        bus_addr = 4'h8; bus_we = 1'b1; bus_wdata = 32'h01;
        @(posedge clk); #1;
        check(gclk == 1'b1 && gate_clk_out[0] == 1'b1, "R9 no truncated pulse",
              {31'h0, gate_clk_out[0]}, 32'h1);
        @(negedge clk);
        bus_we = 1'b0;
        exp_en = exp_en & ~8'h01;

        @(negedge gclk); #2;
        check(gate_clk_out == '0, "R9 low while input low", {24'h0, gate_clk_out}, 32'h0);
        @(posedge gclk); #2;
        check(gate_clk_out == exp_en, "R8 new enables take effect",
              {24'h0, gate_clk_out}, {24'h0, exp_en});

        @(negedge clk);
        bus_read(4'h0, {24'h0, exp_en}, "R4 final status");
        @(negedge clk);
        finish_run();
    end
endmodule